// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock of an I2C bus master from a fast system clock. A single 32-bit divisor word carries two independent 16-bit counts, one for the time SCL is held low and one for the time it is left high. Each count unit stands for eight system clocks, so the SCL rate is the system clock divided by eight times the sum of the two counts. The block drives SCL only by pulling it low. After releasing it, the block waits until the synchronized line reads high before timing the high half. A slave that stretches the clock therefore lengthens the bit instead of shortening it.

Alongside the clock, the block emits single-cycle phase strobes that a bit-level engine uses. One marks the falling edge, one sits at the middle of the low half where SDA may change, one marks the moment SCL is seen high, and one sits at the middle of the high half. The engine samples SDA at that middle-high point, and START and STOP edges are placed there too. The divisor is captured at the start of every low half, so a new rate takes effect on a bit boundary. Clearing the enable releases SCL and returns every counter to its idle value.

Top module: `scl_timer`

## Requirements
- R1: While reset is held, or from the cycle after a clock edge that sees en_i low, scl_low_o is 0 and all four strobes are 0.
- R2: The low half lasts 8*L system cycles, where L is div_i[15:0] captured at the start of that low half.
- R3: The high half, counted from the cycle rise_stb_o is 1, lasts 8*H system cycles, where H is div_i[31:16] captured at the start of the preceding low half.
- R4: A field value of zero is timed as if it were one, so either half is at least 8 cycles long.
- R5: drv_stb_o is 1 for exactly one cycle per low half, in the cycle whose index from the start of the low half is (8*L)/2.
- R6: smp_stb_o is 1 for exactly one cycle per high half, at index (8*H)/2 counted from the rise_stb_o cycle, and only while SCL is released.
- R7: After scl_low_o falls, the high-half count starts only once scl_i has passed through SYNC_STAGES flops. When the line rises at once, the gap from release to rise_stb_o is SYNC_STAGES+1 cycles. A slave holding scl_i low for e extra cycles lengthens the gap to e+SYNC_STAGES+1.
- R8: A change of div_i during a bit does not alter that bit's low or high length. The new value governs the next bit.
- R9: fall_stb_o is 1 exactly in the first cycle of each low half. rise_stb_o is 1 exactly in the first cycle of each high half.
- R10: A clock edge that sees en_i high while the block is idle starts a low half, so scl_low_o and fall_stb_o are 1 in the following cycle.
- R11: At most one of the four strobes is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low releases SCL and idles the counters |
| div_i | input | 32 | Divisor word: [15:0] low count, [31:16] high count |
| scl_i | input | 1 | Sampled SCL line level (asynchronous to clk_i) |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb_o | output | 1 | First cycle of a low half |
| drv_stb_o | output | 1 | Middle of the low half: SDA may change |
| rise_stb_o | output | 1 | First cycle of a high half (SCL observed high) |
| smp_stb_o | output | 1 | Middle of the high half: sample SDA, place START/STOP |

## Verification
An enable or a phase boundary seen at a clock edge shows up on the outputs in the very next cycle. The one exception is the wait for SCL to read high, which adds SYNC_STAGES+1 cycles after release plus any stretch. The middle strobes fall exactly half a phase length into their phase. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge from the same inputs. It then compares all five outputs on the following falling edge, so every comparison lands in the cycle where the registered state has already moved. Dedicated measurements count cycles between strobes for several divisor values, a zero divisor, a stretched line, a mid-bit divisor change and an enable drop.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // each divisor unit spans 2**SCALE_LOG2 system clocks
  localparam int unsigned SCALE_LOG2 = 3;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[g] <= 1'b1;
        else         q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[g] <= 1'b1;
        else         q[g] <= q[g-1];
      end
    end
  end

  assign q_o = q[STAGES-1];

endmodule

// File: rtl/scl_len_calc.sv
module scl_len_calc
  import scl_timer_pkg::*;
#(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned CNT_W   = FIELD_W + SCALE_LOG2
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [CNT_W-1:0]   len_o
);

  logic [CNT_W-1:0] base;

  always_comb begin
    base  = (field_i == '0) ? CNT_W'(1) : CNT_W'(field_i);
    len_o = base << SCALE_LOG2;
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lo_len_i,
  input  logic [CNT_W-1:0] hi_len_i,
  input  logic             scl_hi_i,
  output scl_phase_e       ph_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lo_mid_o,
  output logic [CNT_W-1:0] hi_mid_o
);

  scl_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic             lo_end, hi_end;

  // lengths are never below 8, so the subtraction cannot wrap
  assign lo_end = (cnt_q == lo_q - CNT_W'(1));
  assign hi_end = (cnt_q == hi_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      lo_q  <= CNT_W'(8);
      hi_q  <= CNT_W'(8);
    end else if (!en_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_q  <= PH_LOW;
          cnt_q <= '0;
          lo_q  <= lo_len_i;
          hi_q  <= hi_len_i;
        end
        PH_LOW: begin
          if (lo_end) begin
            ph_q  <= PH_WAIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_WAIT: begin
          if (scl_hi_i) begin
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
          end
        end
        PH_HIGH: begin
          if (hi_end) begin
            ph_q  <= PH_LOW;
            cnt_q <= '0;
            lo_q  <= lo_len_i;
            hi_q  <= hi_len_i;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign ph_o     = ph_q;
  assign cnt_o    = cnt_q;
  assign lo_mid_o = lo_q >> 1;
  assign hi_mid_o = hi_q >> 1;

endmodule

// File: rtl/scl_timer.sv
module scl_timer
  import scl_timer_pkg::*;
#(
  parameter int unsigned DIV_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             scl_i,
  output logic             scl_low_o,
  output logic             fall_stb_o,
  output logic             drv_stb_o,
  output logic             rise_stb_o,
  output logic             smp_stb_o
);

  localparam int unsigned FIELD_W = DIV_W / 2;
  localparam int unsigned CNT_W   = FIELD_W + SCALE_LOG2;

  logic             scl_sync;
  logic [CNT_W-1:0] len_w [2];
  scl_phase_e       ph;
  logic [CNT_W-1:0] cnt, lo_mid, hi_mid;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (scl_i),
    .q_o    (scl_sync)
  );

  // index 0: low field, index 1: high field
  for (genvar g = 0; g < 2; g++) begin : g_len
    scl_len_calc #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_len (
      .field_i (div_i[g*FIELD_W +: FIELD_W]),
      .len_o   (len_w[g])
    );
  end

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .lo_len_i (len_w[0]),
    .hi_len_i (len_w[1]),
    .scl_hi_i (scl_sync),
    .ph_o     (ph),
    .cnt_o    (cnt),
    .lo_mid_o (lo_mid),
    .hi_mid_o (hi_mid)
  );

  always_comb begin
    scl_low_o  = (ph == PH_LOW);
    fall_stb_o = (ph == PH_LOW)  && (cnt == '0);
    drv_stb_o  = (ph == PH_LOW)  && (cnt == lo_mid);
    rise_stb_o = (ph == PH_HIGH) && (cnt == '0);
    smp_stb_o  = (ph == PH_HIGH) && (cnt == hi_mid);
  end

endmodule

// File: rtl/scl_timer_chk.sv
module scl_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_sync,
  input logic scl_low_o,
  input logic fall_stb_o,
  input logic drv_stb_o,
  input logic rise_stb_o,
  input logic smp_stb_o
);

  // R1
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_low_o && !fall_stb_o && !drv_stb_o && !rise_stb_o && !smp_stb_o));

  // R11
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_stb_o, drv_stb_o, rise_stb_o, smp_stb_o}));

  // R9
  low_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_low_o) |-> fall_stb_o);

  // R9
  fall_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |-> scl_low_o);

  // R7
  rise_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_stb_o |-> ($past(scl_sync) && !scl_low_o));

  // R6
  smp_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_o |-> !scl_low_o);

  // R5
  drv_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_stb_o |-> scl_low_o);

endmodule

bind scl_timer scl_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .scl_sync   (scl_sync),
  .scl_low_o  (scl_low_o),
  .fall_stb_o (fall_stb_o),
  .drv_stb_o  (drv_stb_o),
  .rise_stb_o (rise_stb_o),
  .smp_stb_o  (smp_stb_o)
);

// File: tb/tb_scl_timer.sv
module tb_scl_timer;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [31:0] div = '0;
  logic        stretch = 1'b0;
  logic        scl_line;
  logic        scl_low, fall_stb, drv_stb, rise_stb, smp_stb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !scl_low && !stretch;

  scl_timer #(.DIV_W(32), .SYNC_STAGES(SYNC)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .div_i      (div),
    .scl_i      (scl_line),
    .scl_low_o  (scl_low),
    .fall_stb_o (fall_stb),
    .drv_stb_o  (drv_stb),
    .rise_stb_o (rise_stb),
    .smp_stb_o  (smp_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int flen(input logic [15:0] f);
    return (f == 16'd0) ? 8 : 8 * int'(f);
  endfunction

  // behavioural reference: phase 0 idle, 1 low, 2 wait, 3 high
  int m_ph, m_el, m_lo, m_hi;
  bit m_sq[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_el = 0; m_lo = 8; m_hi = 8;
      m_sq = {};
      for (int i = 0; i < SYNC; i++) m_sq.push_back(1'b1);
    end else begin
      bit line_now, seen_hi;
      line_now = !(m_ph == 1) && !stretch;
      seen_hi  = m_sq[SYNC-1];
      if (!en) begin
        m_ph = 0; m_el = 0;
      end else begin
        case (m_ph)
          0: begin m_ph = 1; m_el = 0; m_lo = flen(div[15:0]); m_hi = flen(div[31:16]); end
          1: if (m_el == m_lo - 1) begin m_ph = 2; m_el = 0; end else m_el++;
          2: if (seen_hi) begin m_ph = 3; m_el = 0; end
          default: if (m_el == m_hi - 1) begin
                     m_ph = 1; m_el = 0; m_lo = flen(div[15:0]); m_hi = flen(div[31:16]);
                   end else m_el++;
        endcase
      end
      m_sq.push_front(line_now);
      void'(m_sq.pop_back());
    end
  end

  // cycle compare away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(scl_low  == (m_ph == 1),                 "R2", "model scl_low",  scl_low,  m_ph == 1);
      chk(fall_stb == (m_ph == 1 && m_el == 0),    "R9", "model fall_stb", fall_stb, m_ph == 1 && m_el == 0);
      chk(drv_stb  == (m_ph == 1 && m_el == m_lo/2), "R5", "model drv_stb", drv_stb, m_ph == 1 && m_el == m_lo/2);
      chk(rise_stb == (m_ph == 3 && m_el == 0),    "R7", "model rise_stb", rise_stb, m_ph == 3 && m_el == 0);
      chk(smp_stb  == (m_ph == 3 && m_el == m_hi/2), "R6", "model smp_stb", smp_stb, m_ph == 3 && m_el == m_hi/2);
      chk($countones({fall_stb, drv_stb, rise_stb, smp_stb}) <= 1, "R11", "strobe count",
          $countones({fall_stb, drv_stb, rise_stb, smp_stb}), 1);
    end
  end

  // measure one bit starting at the next fall strobe
  task automatic measure(input int lo_exp, input int hi_exp, input int extra,
                         input bit swap, input logic [31:0] div_new, input string req);
    int n, w, h, dpos, spos;
    @(negedge clk);
    while (!fall_stb) @(negedge clk);
    stretch = (extra > 0);
    n = 0; dpos = -1;
    while (scl_low) begin
      if (drv_stb) dpos = n;
      if (swap && n == 1) div = div_new;
      n++;
      @(negedge clk);
    end
    chk(n == lo_exp, req, "low length", n, lo_exp);
    chk(dpos == lo_exp/2, "R5", "drive strobe index", dpos, lo_exp/2);
    w = 0;
    while (1) begin
      if (rise_stb) break;
      if (w >= extra) stretch = 1'b0;
      w++;
      @(negedge clk);
    end
    chk(w == extra + SYNC + 1, "R7", "release to rise", w, extra + SYNC + 1);
    h = 0; spos = -1;
    while (!fall_stb) begin
      if (smp_stb) spos = h;
      h++;
      @(negedge clk);
    end
    chk(h == hi_exp, (req == "R2") ? "R3" : req, "high length", h, hi_exp);
    chk(spos == hi_exp/2, "R6", "sample strobe index", spos, hi_exp/2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!scl_low && !fall_stb && !drv_stb && !rise_stb && !smp_stb, "R1", "reset outputs",
        {scl_low, fall_stb, drv_stb, rise_stb, smp_stb}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_low && !fall_stb, "R1", "disabled outputs", {scl_low, fall_stb}, 0);

    div = {16'd3, 16'd2};
    en = 1'b1;
    @(negedge clk);
    chk(scl_low && fall_stb, "R10", "start after enable", {scl_low, fall_stb}, 2'b11);
    measure(16, 24, 0, 1'b0, '0, "R2");
    measure(16, 24, 0, 1'b0, '0, "R2");

    // R4 zero fields
    div = '0;
    measure(8, 8, 0, 1'b0, '0, "R4");

    // R7 stretched line
    div = {16'd2, 16'd1};
    measure(8, 16, 10, 1'b0, '0, "R7");

    // R8 divisor change inside a bit
    div = {16'd2, 16'd3};
    measure(24, 16, 0, 1'b0, '0, "R8");
    measure(24, 16, 0, 1'b1, {16'd1, 16'd5}, "R8");
    measure(40, 8, 0, 1'b0, '0, "R8");

    // long high field
    div = {16'd16, 16'd1};
    measure(8, 128, 0, 1'b0, '0, "R3");

    // R10 / R1 enable drop in the high half
    @(negedge clk);
    while (!rise_stb) @(negedge clk);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_low && !fall_stb && !drv_stb && !rise_stb && !smp_stb, "R1", "off after drop",
        {scl_low, fall_stb, drv_stb, rise_stb, smp_stb}, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!scl_low, "R10", "idle stays released", scl_low, 0);
    end
    en = 1'b1;
    @(negedge clk);
    chk(scl_low && fall_stb, "R10", "restart after enable", {scl_low, fall_stb}, 2'b11);
    measure(8, 128, 0, 1'b0, '0, "R2");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule